// File: doc/BRIEF.md
# Reset Strap Configuration Latch

This block captures configuration pins that a PHY-class device shares with its data outputs. While the synchronous reset is high, the block samples the strap inputs on every clock edge. The value sampled at the last edge with reset high is kept for as long as the device runs. These captured values seed a 16-bit basic control register and a 16-bit capability advertisement register. They also fix the data-interface mode and the three-bit station address. Once reset drops, the block raises a pad output enable so that the shared pins can become outputs. From then on the strap inputs have no effect.

Software-side logic can later change the control and advertisement fields through a one-cycle write port. Bit 9 of the control register is a restart request that clears itself. Writing a one to it produces a single-cycle restart pulse. The port has no back-pressure: a write is accepted in the cycle where `wr_en` is high, and the result is visible from the next cycle. A mode code that is not defined falls back to MII operation and raises an error flag. That flag stays set until the next reset captures a valid code.

Top module: `strap_cfg_latch`

## Requirements
- R1: After reset, control register bit 13 holds the speed strap (1 = 100 Mb/s), bit 12 the auto-negotiation enable strap, bit 10 the isolate strap and bit 8 the duplex strap (1 = full), all as sampled at the last clock edge with reset high; all other control bits read 0 until written.
- R2: After reset, the advertisement register holds bit 8 = speed AND duplex, bit 7 = speed, bit 6 = duplex, bit 5 = 1, bits 4:0 = 00001, and 0 in all other bits.
- R3: The 3-bit mode strap decodes 000 to MII (`if_mode` = 0), 001 to RMII (`if_mode` = 1) and 100 to PCS loopback (`if_mode` = 2), with `cfg_err` low.
- R4: Any other mode code gives `if_mode` = 0 (MII) and sets `cfg_err`, which holds at 1 until a reset captures a valid code.
- R5: `phy_addr` equals the address straps sampled at the last clock edge with reset high.
- R6: Once reset is low, changes on any strap input leave every output unchanged.
- R7: A write with `wr_sel` = 0 loads bits 13, 12, 10 and 8 of `wr_data` into the control register, visible in the next cycle; other written bits, except bit 9, are dropped.
- R8: A control write with bit 9 set makes `restart_pulse` and control bit 9 high for exactly the one cycle after the write; both read 0 afterwards.
- R9: A write with `wr_sel` = 1 loads bits 8:5 of `wr_data` into the advertisement register, visible in the next cycle; bits 4:0 stay 00001 and all other bits stay 0.
- R10: `pad_oe` is 0 while reset is high and is 1 from the cycle after reset is released.
- R11: Writes presented while reset is high are ignored; the straps decide the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; straps are sampled while high |
| strap_mode | input | 3 | Interface mode strap code |
| strap_addr | input | 3 | Station address straps |
| strap_iso | input | 1 | Isolate strap |
| strap_speed | input | 1 | Speed strap, 1 = 100 Mb/s |
| strap_duplex | input | 1 | Duplex strap, 1 = full |
| strap_aneg | input | 1 | Auto-negotiation enable strap |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = advertisement register |
| wr_data | input | 16 | Write data |
| ctrl_reg | output | 16 | Basic control register contents |
| adv_reg | output | 16 | Advertisement register contents |
| if_mode | output | 2 | Decoded interface mode: 0 MII, 1 RMII, 2 loopback |
| phy_addr | output | 3 | Latched station address |
| cfg_err | output | 1 | Sticky flag for a reserved mode code |
| restart_pulse | output | 1 | One-cycle restart request |
| pad_oe | output | 1 | Shared pins may drive as outputs |

## Verification
The bench checks all eight mode codes, because a design that decodes only the low bits would treat 101 as RMII or 110 as loopback. It changes the straps right after reset is released; a latch that keeps sampling would follow those changes. The restart bit is checked in the cycle after a write and again one cycle later, which catches a bit that sticks or a pulse that comes a cycle late. Writes presented during reset and writes to the fixed selector bits show whether the strap values and the constant fields really take priority.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
  typedef enum logic [1:0] {
    IFM_MII  = 2'd0,
    IFM_RMII = 2'd1,
    IFM_LOOP = 2'd2
  } if_mode_e;

  localparam int REG_W        = 16;
  localparam int MODE_W       = 3;
  localparam int BIT_SPEED    = 13;
  localparam int BIT_ANEG     = 12;
  localparam int BIT_ISO      = 10;
  localparam int BIT_RESTART  = 9;
  localparam int BIT_DUPLEX   = 8;
  localparam int ADV_100FD    = 8;
  localparam int ADV_100HD    = 7;
  localparam int ADV_10FD     = 6;
  localparam int ADV_10HD     = 5;
  localparam int SEL_W        = 5;
  localparam logic [SEL_W-1:0] ADV_SELECTOR = 5'b00001;
endpackage

// File: rtl/strap_mode_latch.sv
module strap_mode_latch
  import strap_cfg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] strap_mode,
  input  logic [ADDR_W-1:0] strap_addr,
  output if_mode_e          if_mode,
  output logic [ADDR_W-1:0] phy_addr,
  output logic              cfg_err,
  output logic              pad_oe
);
  if_mode_e mode_d;
  logic     bad_d;

  always_comb begin
    bad_d  = 1'b0;
    case (strap_mode)
      3'b000:  mode_d = IFM_MII;
      3'b001:  mode_d = IFM_RMII;
      3'b100:  mode_d = IFM_LOOP;
      default: begin
        mode_d = IFM_MII;
        bad_d  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if_mode  <= mode_d;
      cfg_err  <= bad_d;
      phy_addr <= strap_addr;
      pad_oe   <= 1'b0;
    end else begin
      pad_oe   <= 1'b1;
    end
  end

  p_mode_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(if_mode) && $stable(cfg_err)));
  p_addr_stable_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(phy_addr));
  p_err_mii_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (if_mode == IFM_MII));
  p_oe_after_release_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pad_oe);
endmodule

// File: rtl/strap_ctrl_regs.sv
module strap_ctrl_regs
  import strap_cfg_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_iso,
  input  logic              strap_speed,
  input  logic              strap_duplex,
  input  logic              strap_aneg,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctrl_reg,
  output logic [DATA_W-1:0] adv_reg,
  output logic              restart_pulse
);
  localparam int NFIELD = 4;
  localparam int CTRL_POS [NFIELD] = '{BIT_SPEED, BIT_ANEG, BIT_ISO, BIT_DUPLEX};
  localparam int ADV_POS  [NFIELD] = '{ADV_100FD, ADV_100HD, ADV_10FD, ADV_10HD};
  localparam logic [DATA_W-1:0] RESTART_MASK = DATA_W'(1) << BIT_RESTART;

  logic [NFIELD-1:0] ctrl_seed, adv_seed, ctrl_q, adv_q;
  logic              ctrl_wr, adv_wr, restart_q;
  logic              unused_wr_bits;

  assign ctrl_seed = {strap_speed, strap_aneg, strap_iso, strap_duplex};
  assign adv_seed  = {strap_speed & strap_duplex, strap_speed, strap_duplex, 1'b1};
  assign ctrl_wr   = wr_en && !wr_sel;
  assign adv_wr    = wr_en && wr_sel;
  assign unused_wr_bits = ^wr_data;

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_q[NFIELD-1-i] <= ctrl_seed[NFIELD-1-i];
        adv_q[NFIELD-1-i]  <= adv_seed[NFIELD-1-i];
      end else begin
        if (ctrl_wr) ctrl_q[NFIELD-1-i] <= wr_data[CTRL_POS[i]];
        if (adv_wr)  adv_q[NFIELD-1-i]  <= wr_data[ADV_POS[i]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) restart_q <= 1'b0;
    else     restart_q <= ctrl_wr && wr_data[BIT_RESTART];
  end

  always_comb begin
    ctrl_reg = '0;
    adv_reg  = '0;
    for (int i = 0; i < NFIELD; i++) begin
      ctrl_reg[CTRL_POS[i]] = ctrl_q[NFIELD-1-i];
      adv_reg[ADV_POS[i]]   = adv_q[NFIELD-1-i];
    end
    ctrl_reg[BIT_RESTART] = restart_q;
    adv_reg[SEL_W-1:0]    = ADV_SELECTOR;
  end

  assign restart_pulse = restart_q;

  p_restart_cause_r8: assert property (@(posedge clk) disable iff (rst)
    restart_pulse |-> $past(wr_en && !wr_sel && wr_data[BIT_RESTART]));
  p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |-> $stable(ctrl_reg & ~RESTART_MASK));
  p_adv_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(adv_wr)) |-> $stable(adv_reg));
  p_restart_bit_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |-> !ctrl_reg[BIT_RESTART]);
endmodule

// File: rtl/strap_cfg_latch.sv
module strap_cfg_latch
  import strap_cfg_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        strap_mode,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              strap_iso,
  input  logic              strap_speed,
  input  logic              strap_duplex,
  input  logic              strap_aneg,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctrl_reg,
  output logic [DATA_W-1:0] adv_reg,
  output logic [1:0]        if_mode,
  output logic [ADDR_W-1:0] phy_addr,
  output logic              cfg_err,
  output logic              restart_pulse,
  output logic              pad_oe
);
  if_mode_e mode_e;

  strap_mode_latch #(.ADDR_W(ADDR_W)) u_mode (
    .clk        (clk),
    .rst        (rst),
    .strap_mode (strap_mode),
    .strap_addr (strap_addr),
    .if_mode    (mode_e),
    .phy_addr   (phy_addr),
    .cfg_err    (cfg_err),
    .pad_oe     (pad_oe)
  );

  strap_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk           (clk),
    .rst           (rst),
    .strap_iso     (strap_iso),
    .strap_speed   (strap_speed),
    .strap_duplex  (strap_duplex),
    .strap_aneg    (strap_aneg),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .ctrl_reg      (ctrl_reg),
    .adv_reg       (adv_reg),
    .restart_pulse (restart_pulse)
  );

  assign if_mode = mode_e;

  p_reset_ignores_write_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !restart_pulse);
endmodule

// File: tb/strap_cfg_latch_test.sv
module strap_cfg_latch_test;
  localparam int PERIOD = 10;

  typedef struct packed {
    logic [2:0]  mode;
    logic        iso, spd, dup, an;
    logic [2:0]  addr;
    logic [15:0] ctrl, adv;
    logic [1:0]  emode;
    logic        err;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 3'd1, 16'h3100, 16'h01E1, 2'd0, 1'b0},
    '{3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 3'd7, 16'h0400, 16'h0021, 2'd1, 1'b0},
    '{3'b100, 1'b0, 1'b1, 1'b0, 1'b1, 3'd3, 16'h3000, 16'h00A1, 2'd2, 1'b0},
    '{3'b010, 1'b0, 1'b0, 1'b1, 1'b0, 3'd5, 16'h0100, 16'h0061, 2'd0, 1'b1},
    '{3'b111, 1'b1, 1'b1, 1'b1, 1'b1, 3'd6, 16'h3500, 16'h01E1, 2'd0, 1'b1},
    '{3'b101, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 16'h1000, 16'h0021, 2'd0, 1'b1},
    '{3'b011, 1'b1, 1'b1, 1'b0, 1'b0, 3'd4, 16'h2400, 16'h00A1, 2'd0, 1'b1},
    '{3'b110, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 16'h1100, 16'h0061, 2'd0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] strap_mode = '0;
  logic [2:0] strap_addr = '0;
  logic strap_iso = 1'b0, strap_speed = 1'b0, strap_duplex = 1'b0, strap_aneg = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] ctrl_reg, adv_reg;
  logic [1:0] if_mode;
  logic [2:0] phy_addr;
  logic cfg_err, restart_pulse, pad_oe;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  strap_cfg_latch uut (
    .clk(clk), .rst(rst), .strap_mode(strap_mode), .strap_addr(strap_addr),
    .strap_iso(strap_iso), .strap_speed(strap_speed), .strap_duplex(strap_duplex),
    .strap_aneg(strap_aneg), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_reg(ctrl_reg), .adv_reg(adv_reg), .if_mode(if_mode), .phy_addr(phy_addr),
    .cfg_err(cfg_err), .restart_pulse(restart_pulse), .pad_oe(pad_oe)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_straps(input vec_t v);
    strap_mode = v.mode; strap_iso = v.iso; strap_speed = v.spd;
    strap_duplex = v.dup; strap_aneg = v.an; strap_addr = v.addr;
  endtask

  task automatic reset_with(input vec_t v);
    set_straps(v);
    rst = 1'b1;
    cyc(); cyc(); cyc();
    chk("R10 pad_oe in reset", {31'd0, pad_oe}, 32'd0);
    rst = 1'b0;
    cyc();
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    cyc();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // Table walk: R1 R2 R3 R4 R5 R10
    for (int i = 0; i < 8; i++) begin
      reset_with(VEC[i]);
      chk("R1 ctrl", {16'd0, ctrl_reg}, {16'd0, VEC[i].ctrl});
      chk("R2 adv", {16'd0, adv_reg}, {16'd0, VEC[i].adv});
      chk(VEC[i].err ? "R4 mode" : "R3 mode", {30'd0, if_mode}, {30'd0, VEC[i].emode});
      chk("R4 cfg_err", {31'd0, cfg_err}, {31'd0, VEC[i].err});
      chk("R5 addr", {29'd0, phy_addr}, {29'd0, VEC[i].addr});
      chk("R10 pad_oe released", {31'd0, pad_oe}, 32'd1);
    end

    // R6 and R4 stickiness: reserved code captured last, now drive a valid set
    set_straps(VEC[0]);
    cyc(); cyc();
    chk("R6 ctrl", {16'd0, ctrl_reg}, {16'd0, VEC[7].ctrl});
    chk("R6 adv", {16'd0, adv_reg}, {16'd0, VEC[7].adv});
    chk("R6 addr", {29'd0, phy_addr}, 32'd0);
    chk("R4 err sticky", {31'd0, cfg_err}, 32'd1);
    set_straps(VEC[2]);
    cyc();
    chk("R6 mode", {30'd0, if_mode}, 32'd0);

    // R11: writes during reset lose to the straps
    set_straps(VEC[1]);
    rst = 1'b1;
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'hFFFF;
    cyc();
    wr_sel = 1'b1;
    cyc();
    wr_en = 1'b0; wr_data = '0;
    rst = 1'b0;
    cyc();
    chk("R11 ctrl", {16'd0, ctrl_reg}, 32'h0400);
    chk("R11 adv", {16'd0, adv_reg}, 32'h0021);
    chk("R11 restart", {31'd0, restart_pulse}, 32'd0);
    chk("R4 err cleared by valid reset", {31'd0, cfg_err}, 32'd0);

    // R7 R8: control writes and the self-clearing restart bit
    wr(1'b0, 16'hFFFF);
    chk("R7 ctrl all ones", {16'd0, ctrl_reg}, 32'h3700);
    chk("R8 pulse high", {31'd0, restart_pulse}, 32'd1);
    cyc();
    chk("R8 bit cleared", {16'd0, ctrl_reg}, 32'h3500);
    chk("R8 pulse low", {31'd0, restart_pulse}, 32'd0);
    wr(1'b0, 16'h0200);
    chk("R8 restart only", {16'd0, ctrl_reg}, 32'h0200);
    cyc();
    chk("R8 restart gone", {16'd0, ctrl_reg}, 32'h0000);
    wr(1'b0, 16'h1100);
    chk("R7 partial", {16'd0, ctrl_reg}, 32'h1100);
    chk("R7 no pulse", {31'd0, restart_pulse}, 32'd0);

    // R9: advertisement writes; selector fixed
    wr(1'b1, 16'hFFFF);
    chk("R9 adv ones", {16'd0, adv_reg}, 32'h01E1);
    chk("R9 ctrl untouched", {16'd0, ctrl_reg}, 32'h1100);
    chk("R9 no pulse", {31'd0, restart_pulse}, 32'd0);
    wr(1'b1, 16'h0000);
    chk("R9 adv zeros", {16'd0, adv_reg}, 32'h0001);
    wr(1'b1, 16'h00A0);
    chk("R9 adv partial", {16'd0, adv_reg}, 32'h00A1);

    finish_run();
  end
endmodule